// File: doc/BRIEF.md
# Stride Stream Prefetch Detector

This block sits beside a lower-level cache and watches the addresses of the misses that cache reports. It looks for a stream: a series of misses inside one 4 KB page whose 128-byte line addresses step by a constant amount. The step may go up or down. When three misses in a row show the same non-zero step, the block predicts the next two lines of the run. It offers them as prefetch requests on a valid/ready channel, nearest line first.

The block tracks a single stream. A miss in another page, or a miss that breaks the step, starts detection again. It also withdraws any predicted line that the downstream side has not yet taken. A repeated miss to the line just seen leaves the block unchanged. A predicted line that would fall outside the current page is never issued.

Top module: `stride_prefetch_detector`

## Requirements
- R1: After reset, `pf_valid` is low and no miss seen before reset counts toward a later stream.
- R2: The line is taken from `miss_addr[11:7]` and the page from `miss_addr[31:12]`; bits [6:0] have no effect. The step is the signed difference of line indices, in lines.
- R3: On the third miss in a row inside one page with equal non-zero steps, `pf_valid` rises in the cycle after that miss is sampled. The first request is that miss's line plus one step, and the second is plus two steps. Two misses alone never raise `pf_valid`.
- R4: Each further miss that keeps the same step issues a fresh pair, counted from that newest miss.
- R5: A predicted line outside lines 0 to 31 of the page is dropped. Every `pf_addr` lies in the page of the latest miss and has bits [6:0] at zero.
- R6: The requests leave in order, nearest first. While `pf_ready` is low and no miss arrives, `pf_valid` and `pf_addr` hold their values.
- R7: A miss to the same line as the previous miss changes neither the step, the match count nor the pending requests.
- R8: Negative steps are detected and predicted in the same way as positive ones.
- R9: A miss in the same page with a different non-zero step becomes the new step with one match, and withdraws all requests not yet accepted.
- R10: A miss in a different page restarts detection from that miss and withdraws all requests not yet accepted.
- R11: Misses whose successive steps all differ never raise `pf_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| miss_valid | input | 1 | A miss address is present this cycle |
| miss_addr | input | 32 | Byte address of the miss |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | Downstream takes the offered request this cycle |
| pf_addr | output | 32 | Line-aligned address of the offered request |

## Verification
Several properties are checked every cycle:
- a request appears only in the cycle after a miss;
- a stalled request holds steady;
- every offered address is line-aligned and inside the page of the latest miss;
- a page change empties the channel;
- a repeated miss to the same line disturbs nothing.

Some behaviour is shown only by the bench's scenarios. These include the exact predicted addresses for rising and falling steps, and the partial drop at a page edge where one line fits and the next does not. They also include the recovery of a stream after a repeated miss, the silence under an irregular visiting order, and the loss of history across a reset.

// File: rtl/spd_pkg.sv
package spd_pkg;

  // Number of consecutive equal non-zero steps seen so far.
  typedef enum logic [1:0] {
    MATCH_NONE = 2'd0,
    MATCH_ONE  = 2'd1,
    MATCH_TWO  = 2'd2
  } match_e;

endpackage

// File: rtl/spd_stride_tracker.sv
module spd_stride_tracker #(
  parameter int IDX_W = 5,
  parameter int PG_W  = 20,
  localparam int STR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  logic [PG_W-1:0]  miss_page,
  input  logic [IDX_W-1:0] miss_idx,
  output logic             trig,
  output logic             cancel,
  output logic [PG_W-1:0]  trig_page,
  output logic [IDX_W-1:0] trig_idx,
  output logic [STR_W-1:0] trig_stride
);
  import spd_pkg::*;

  logic              have_q, have_d;
  logic [PG_W-1:0]   page_q, page_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [STR_W-1:0]  stride_q, stride_d;
  match_e            cnt_q, cnt_d;
  logic              upd_en;

  logic signed [STR_W-1:0] delta;
  logic                    same_page;

  assign delta     = $signed({1'b0, miss_idx}) - $signed({1'b0, idx_q});
  assign same_page = have_q && (miss_page == page_q);

  assign trig_page   = miss_page;
  assign trig_idx    = miss_idx;
  assign trig_stride = delta;
  assign upd_en      = miss_valid;

  always_comb begin
    have_d   = have_q;
    page_d   = page_q;
    idx_d    = idx_q;
    stride_d = stride_q;
    cnt_d    = cnt_q;
    trig     = 1'b0;
    cancel   = 1'b0;
    if (miss_valid) begin
      if (!same_page) begin
        // new page: this miss is the first of a possible stream
        have_d   = 1'b1;
        page_d   = miss_page;
        idx_d    = miss_idx;
        stride_d = '0;
        cnt_d    = MATCH_NONE;
        cancel   = 1'b1;
      end else if (delta == '0) begin
        // repeated line: state untouched
      end else if ((cnt_q != MATCH_NONE) && (delta == $signed(stride_q))) begin
        idx_d = miss_idx;
        cnt_d = MATCH_TWO;
        trig  = 1'b1;
      end else begin
        idx_d    = miss_idx;
        stride_d = delta;
        cnt_d    = MATCH_ONE;
        cancel   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q   <= 1'b0;
      page_q   <= '0;
      idx_q    <= '0;
      stride_q <= '0;
      cnt_q    <= MATCH_NONE;
    end else if (upd_en) begin
      have_q   <= have_d;
      page_q   <= page_d;
      idx_q    <= idx_d;
      stride_q <= stride_d;
      cnt_q    <= cnt_d;
    end
  end

endmodule

// File: rtl/spd_prefetch_queue.sv
module spd_prefetch_queue #(
  parameter int IDX_W = 5,
  parameter int PG_W  = 20,
  parameter int AHEAD = 2,
  localparam int STR_W = IDX_W + 1,
  localparam int TGT_W = STR_W + $clog2(AHEAD + 1) + 1,
  localparam int HW    = (AHEAD > 1) ? $clog2(AHEAD) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             cancel,
  input  logic [PG_W-1:0]  trig_page,
  input  logic [IDX_W-1:0] trig_idx,
  input  logic [STR_W-1:0] trig_stride,
  input  logic             pf_ready,
  output logic             pf_valid,
  output logic [PG_W-1:0]  pf_page,
  output logic [IDX_W-1:0] pf_idx
);

  logic [AHEAD-1:0] v_q, v_d;
  logic [IDX_W-1:0] a_q [AHEAD];
  logic [IDX_W-1:0] a_d [AHEAD];
  logic [PG_W-1:0]  page_q, page_d;
  logic [HW-1:0]    head;
  logic             upd_en;

  logic signed [TGT_W-1:0] base, step;
  logic [AHEAD-1:0]        tgt_ok;
  logic [IDX_W-1:0]        tgt_idx [AHEAD];

  assign base = $signed(TGT_W'(trig_idx));
  assign step = $signed({{(TGT_W-STR_W){trig_stride[STR_W-1]}}, trig_stride});

  for (genvar g = 0; g < AHEAD; g++) begin : g_tgt
    localparam logic signed [TGT_W-1:0] MUL = TGT_W'(g + 1);
    logic signed [TGT_W-1:0] tgt;
    assign tgt        = base + step * MUL;
    assign tgt_ok[g]  = (tgt[TGT_W-1:IDX_W] == '0);
    assign tgt_idx[g] = tgt[IDX_W-1:0];
  end

  // lowest valid slot is the nearest line
  always_comb begin
    head = '0;
    for (int i = AHEAD - 1; i >= 0; i--) begin
      if (v_q[i]) head = HW'(i);
    end
  end

  assign pf_valid = |v_q;
  assign pf_idx   = a_q[head];
  assign pf_page  = page_q;
  assign upd_en   = cancel | trig | (pf_valid & pf_ready);

  always_comb begin
    v_d    = v_q;
    page_d = page_q;
    for (int i = 0; i < AHEAD; i++) a_d[i] = a_q[i];
    if (cancel) begin
      v_d = '0;
    end else if (trig) begin
      v_d    = tgt_ok;
      page_d = trig_page;
      for (int i = 0; i < AHEAD; i++) a_d[i] = tgt_idx[i];
    end else if (pf_valid && pf_ready) begin
      v_d[head] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= '0;
      page_q <= '0;
      for (int i = 0; i < AHEAD; i++) a_q[i] <= '0;
    end else if (upd_en) begin
      v_q    <= v_d;
      page_q <= page_d;
      for (int i = 0; i < AHEAD; i++) a_q[i] <= a_d[i];
    end
  end

endmodule

// File: rtl/stride_prefetch_detector.sv
module stride_prefetch_detector #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 7,
  parameter int PAGE_BITS = 12,
  parameter int AHEAD     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int IDX_W = PAGE_BITS - LINE_BITS;
  localparam int PG_W  = ADDR_W - PAGE_BITS;
  localparam int STR_W = IDX_W + 1;

  logic [PG_W-1:0]  miss_page, trig_page, pf_page;
  logic [IDX_W-1:0] miss_idx, trig_idx, pf_idx;
  logic [STR_W-1:0] trig_stride;
  logic             trig, cancel;
  logic             unused_ofs;

  assign miss_page  = miss_addr[ADDR_W-1:PAGE_BITS];
  assign miss_idx   = miss_addr[PAGE_BITS-1:LINE_BITS];
  assign unused_ofs = ^miss_addr[LINE_BITS-1:0];

  spd_stride_tracker #(.IDX_W(IDX_W), .PG_W(PG_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .miss_valid  (miss_valid),
    .miss_page   (miss_page),
    .miss_idx    (miss_idx),
    .trig        (trig),
    .cancel      (cancel),
    .trig_page   (trig_page),
    .trig_idx    (trig_idx),
    .trig_stride (trig_stride)
  );

  spd_prefetch_queue #(.IDX_W(IDX_W), .PG_W(PG_W), .AHEAD(AHEAD)) u_queue (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig        (trig),
    .cancel      (cancel),
    .trig_page   (trig_page),
    .trig_idx    (trig_idx),
    .trig_stride (trig_stride),
    .pf_ready    (pf_ready),
    .pf_valid    (pf_valid),
    .pf_page     (pf_page),
    .pf_idx      (pf_idx)
  );

  assign pf_addr = {pf_page, pf_idx, {LINE_BITS{1'b0}}};

endmodule

// File: rtl/spd_checker.sv
module spd_checker #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 7,
  parameter int PAGE_BITS = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic [ADDR_W-1:0] miss_addr,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr
);
  localparam int LN_W = ADDR_W - LINE_BITS;
  localparam int PG_W = ADDR_W - PAGE_BITS;

  logic            chk_have_q;
  logic [LN_W-1:0] chk_line_q;
  logic [PG_W-1:0] chk_page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_have_q <= 1'b0;
      chk_line_q <= '0;
    end else if (miss_valid) begin
      chk_have_q <= 1'b1;
      chk_line_q <= miss_addr[ADDR_W-1:LINE_BITS];
    end
  end

  assign chk_page = chk_line_q[LN_W-1:PAGE_BITS-LINE_BITS];

  always @(posedge clk) begin
    if (!rst_n) assert_idle_in_reset_R1: assert (!pf_valid);
  end

  assert_rise_after_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> $past(miss_valid));

  assert_in_page_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (chk_have_q && (pf_addr[LINE_BITS-1:0] == '0)
                  && (pf_addr[ADDR_W-1:PAGE_BITS] == chk_page)));

  assert_hold_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready && !miss_valid) |=> (pf_valid && $stable(pf_addr)));

  assert_repeat_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && chk_have_q && !pf_ready
     && (miss_addr[ADDR_W-1:LINE_BITS] == chk_line_q))
    |=> ($stable(pf_valid) && $stable(pf_addr)));

  assert_page_change_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && chk_have_q && (miss_addr[ADDR_W-1:PAGE_BITS] != chk_page))
    |=> !pf_valid);

endmodule

bind stride_prefetch_detector spd_checker #(
  .ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS), .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .miss_valid (miss_valid),
  .miss_addr  (miss_addr),
  .pf_valid   (pf_valid),
  .pf_ready   (pf_ready),
  .pf_addr    (pf_addr)
);

// File: tb/stride_prefetch_detector_tb.sv
`timescale 1ns/1ps
module stride_prefetch_detector_tb;

  logic        clk;
  logic        rst_n;
  logic        miss_valid;
  logic [31:0] miss_addr;
  logic        pf_valid;
  logic        pf_ready;
  logic [31:0] pf_addr;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  stride_prefetch_detector u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .miss_addr  (miss_addr),
    .pf_valid   (pf_valid),
    .pf_ready   (pf_ready),
    .pf_addr    (pf_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  n;
    logic [31:0] e0;
    logic [31:0] e1;
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{32'h0001_2100, 2'd0, 32'h0,         32'h0,         "R3"},
    '{32'h0001_2280, 2'd0, 32'h0,         32'h0,         "R3"},
    '{32'h0001_2400, 2'd2, 32'h0001_2580, 32'h0001_2700, "R3"},
    '{32'h0001_2580, 2'd2, 32'h0001_2700, 32'h0001_2880, "R4"},
    '{32'h0001_2580, 2'd0, 32'h0,         32'h0,         "R7"},
    '{32'h0001_2700, 2'd2, 32'h0001_2880, 32'h0001_2A00, "R7"},
    '{32'h0001_2780, 2'd0, 32'h0,         32'h0,         "R9"},
    '{32'h0001_2800, 2'd2, 32'h0001_2880, 32'h0001_2900, "R9"},
    '{32'h0001_2E80, 2'd0, 32'h0,         32'h0,         "R9"},
    '{32'h0001_2F00, 2'd0, 32'h0,         32'h0,         "R5"},
    '{32'h0001_2F80, 2'd0, 32'h0,         32'h0,         "R5"},
    '{32'h0001_2E00, 2'd0, 32'h0,         32'h0,         "R8"},
    '{32'h0001_2C80, 2'd2, 32'h0001_2B00, 32'h0001_2980, "R8"},
    '{32'h0001_2B00, 2'd2, 32'h0001_2980, 32'h0001_2800, "R8"},
    '{32'h0003_4300, 2'd0, 32'h0,         32'h0,         "R10"},
    '{32'h0003_4200, 2'd0, 32'h0,         32'h0,         "R8"},
    '{32'h0003_4100, 2'd1, 32'h0003_4000, 32'h0,         "R5"},
    '{32'h0003_4480, 2'd0, 32'h0,         32'h0,         "R11"},
    '{32'h0003_4100, 2'd0, 32'h0,         32'h0,         "R11"},
    '{32'h0003_4A00, 2'd0, 32'h0,         32'h0,         "R11"},
    '{32'h0003_4380, 2'd0, 32'h0,         32'h0,         "R11"},
    '{32'h0003_4680, 2'd0, 32'h0,         32'h0,         "R11"},
    '{32'h0003_46C5, 2'd0, 32'h0,         32'h0,         "R2"},
    '{32'h0003_49FF, 2'd2, 32'h0003_4C80, 32'h0003_4F80, "R2"}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // pulse one miss; returns at the negedge after the edge that sampled it
  task automatic send_miss(input logic [31:0] a);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  // miss with pf_ready high: collect what is offered over three cycles
  task automatic run_vec(input vec_t v);
    logic [31:0] got [2];
    int cnt = 0;
    send_miss(v.addr);
    for (int k = 0; k < 3; k++) begin
      if (pf_valid) begin
        if (cnt < 2) got[cnt] = pf_addr;
        cnt++;
      end
      @(negedge clk);
    end
    check(cnt == int'(v.n), $sformatf("%s count", v.tag), 32'(cnt), 32'(v.n));
    if (cnt >= 1 && v.n >= 1) check(got[0] == v.e0, $sformatf("%s first", v.tag), got[0], v.e0);
    if (cnt >= 2 && v.n >= 2) check(got[1] == v.e1, $sformatf("%s second", v.tag), got[1], v.e1);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n      = 1'b0;
    miss_valid = 1'b0;
    miss_addr  = '0;
    pf_ready   = 1'b1;
    repeat (3) @(negedge clk);
    // R1: idle during and right after reset
    check(pf_valid == 1'b0, "R1 in reset", 32'(pf_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pf_valid == 1'b0, "R1 after reset", 32'(pf_valid), 32'h0);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R6: stalled request holds, then drains nearest first
    pf_ready = 1'b0;
    send_miss(32'h0001_2000);
    send_miss(32'h0001_2200);
    send_miss(32'h0001_2400);
    for (int k = 0; k < 4; k++) begin
      check(pf_valid && pf_addr == 32'h0001_2600, "R6 hold", pf_addr, 32'h0001_2600);
      @(negedge clk);
    end
    pf_ready = 1'b1;
    @(negedge clk);
    check(pf_valid && pf_addr == 32'h0001_2800, "R6 second", pf_addr, 32'h0001_2800);
    @(negedge clk);
    check(pf_valid == 1'b0, "R6 drained", 32'(pf_valid), 32'h0);

    // R9: stride break withdraws pending requests
    pf_ready = 1'b0;
    send_miss(32'h0005_6080);
    send_miss(32'h0005_6100);
    send_miss(32'h0005_6180);
    check(pf_valid && pf_addr == 32'h0005_6200, "R9 pending", pf_addr, 32'h0005_6200);
    send_miss(32'h0005_6500);
    check(pf_valid == 1'b0, "R9 cancel", 32'(pf_valid), 32'h0);

    // R10: page change withdraws pending requests
    send_miss(32'h0007_8080);
    send_miss(32'h0007_8100);
    send_miss(32'h0007_8180);
    check(pf_valid && pf_addr == 32'h0007_8200, "R10 pending", pf_addr, 32'h0007_8200);
    send_miss(32'h0009_A000);
    check(pf_valid == 1'b0, "R10 cancel", 32'(pf_valid), 32'h0);
    pf_ready = 1'b1;

    // R1: reset clears stream history (line 2 would otherwise complete a run)
    send_miss(32'h0009_A080);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pf_valid == 1'b0, "R1 mid reset", 32'(pf_valid), 32'h0);
    run_vec('{32'h0009_A100, 2'd0, 32'h0, 32'h0, "R1"});

    summary();
  end

endmodule